// File: doc/BRIEF.md
# Byte-Serial Peripheral Interface Controller with Mode-Fault Protection

The block moves one byte at a time over a four-wire serial peripheral interface (SCK, MOSI, MISO, SS). Software sets it up through a small register port: a control word selects master or slave operation, clock idle level, clock phase, bit rate, pin ownership and interrupt masking. A data word starts a transfer and returns the byte that was received. A status word reports completion, write collision, overrun and mode fault. As master the block makes SCK from the system clock. As slave it follows an external SCK that it samples after a two-flop synchronizer.

The transfer engine is a three-state machine. `ST_IDLE` holds SCK at its idle level and accepts a new byte. It moves to `ST_RUN` when a master-mode data write arrives, or when a slave sees SS low. `ST_RUN` counts sixteen SCK transitions. On each transition it either captures the input bit or presents the next output bit. After the sixteenth transition it moves to `ST_DONE`. It also returns to `ST_IDLE` early on a mode fault, on pin release, or when a slave's SS goes high. `ST_DONE` lasts one cycle, hands the byte to the data register and returns to `ST_IDLE`.

A low SS while the block is an enabled master is a bus conflict. The hardware drops to a disabled slave, aborts the transfer and raises the mode-fault flag.

Top module: `spi_port`

## Requirements
- R1: After reset the control and status words read 0x00, `irq` is 0, `gpio_sel` is 1, `sck_o` is 0, and `sck_oe`, `mosi_oe` and `miso_oe` are 0.
- R2: Register addresses are: 0 = control, 1 = status, 2 = data. The control word reads back what was written. Its bits are [7] interrupt enable, [6] pin enable, [5] rate bit 2, [4] master select, [3] CPOL, [2] CPHA, [1:0] rate bits 1..0. The status word is [7] done, [6] collision, [5] overrun, [4] mode fault, with [3:0] reading 0.
- R3: In master mode the SCK period, in system clocks, follows {ctl[5],ctl[1:0]}: 100→2, 000→4, 001→8, 110→16, 010→32, 011→64. The unused codes 101 and 111 also give 64.
- R4: While no transfer runs, master SCK rests at the CPOL level (0 low, 1 high).
- R5: Data moves MSB first. With CPHA=0 a bit is captured on the first SCK transition of its bit time; with CPHA=1 on the second.
- R6: In master mode with pin enable set, a data write while idle sends that byte. When the byte completes, the done flag is set and the data register returns the byte received on MISO.
- R7: In slave mode, a byte written beforehand is shifted out on MISO while SS is low and an external SCK runs. The received MOSI byte appears in the data register with the done flag set. The rate bits have no effect in this mode.
- R8: A data write during a transfer sets the collision flag and leaves the byte in flight unchanged.
- R9: If a transfer completes while the done flag is still set, the overrun flag is set and the new byte is discarded; the data register keeps the earlier byte.
- R10: A status read followed by any data-register access clears all four flags.
- R11: If SS is low while master select and pin enable are both 1, both bits are cleared and the mode-fault flag is set.
- R12: `irq` is 1 exactly when interrupt enable is 1 and the done flag or the mode-fault flag is 1.
- R13: `gpio_sel` is the inverse of pin enable. `sck_oe` and `mosi_oe` are 1 only for an enabled master. `miso_oe` is 1 only for an enabled slave with SS low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on flags) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from the pin (slave) |
| sck_o | output | 1 | Serial clock to the pin (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | MOSI from the pin (slave receive) |
| mosi_o | output | 1 | MOSI to the pin (master send) |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO from the pin (master receive) |
| miso_o | output | 1 | MISO to the pin (slave send) |
| miso_oe | output | 1 | MISO output enable |
| ss_n | input | 1 | Slave select, active low |
| gpio_sel | output | 1 | 1 when general-purpose I/O owns the pins |

## Verification
The bench runs all four CPOL/CPHA combinations against a behavioural slave that captures and drives bits only on the proper edges. A phase or bit-order error therefore shows up as a corrupted byte in the scoreboard. It measures the SCK period for the fastest, slowest and an unused rate code, which catches a divider that misreads the non-monotonic encoding. It writes during a slow transfer to expose a design that lets the collision overwrite the shift register. It completes two bytes without a flag clear to catch a design that overwrites the held byte instead of flagging overrun. It pulls SS low on an enabled master, where a design that kept driving, or missed clearing either control bit, is seen in the control readback and in `gpio_sel`.

// File: rtl/spi_pkg.sv
package spi_pkg;

    localparam int unsigned REG_W     = 8;
    localparam int unsigned RATE_CW   = 5;

    localparam logic [1:0] A_CTL  = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    localparam int unsigned C_IE   = 7;
    localparam int unsigned C_PE   = 6;
    localparam int unsigned C_R2   = 5;
    localparam int unsigned C_MS   = 4;
    localparam int unsigned C_CPOL = 3;
    localparam int unsigned C_CPHA = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } xfer_state_t;

    // Half-period length minus one, in system clocks, for a 3-bit rate code.
    function automatic logic [RATE_CW-1:0] rate_limit(input logic [2:0] code);
        logic [RATE_CW-1:0] lim;
        case (code)
            3'b100:  lim = RATE_CW'(0);
            3'b000:  lim = RATE_CW'(1);
            3'b001:  lim = RATE_CW'(3);
            3'b110:  lim = RATE_CW'(7);
            3'b010:  lim = RATE_CW'(15);
            default: lim = RATE_CW'(31);
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= d;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spi_rate_div.sv
module spi_rate_div
    import spi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] code,
    output logic       tick
);

    logic [RATE_CW-1:0] cnt_q;
    logic [RATE_CW-1:0] lim;

    assign lim  = rate_limit(code);
    assign tick = run && (cnt_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3
    div_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $stable(code) && $past(run)) |-> (cnt_q <= lim));

endmodule

// File: rtl/spi_engine.sv
module spi_engine
    import spi_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master,
    input  logic              active,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              tick,
    input  logic              sck_s,
    input  logic              ss_lo,
    input  logic              load,
    input  logic              abort,
    input  logic              din_m,
    input  logic              din_s,
    input  logic [DATA_W-1:0] load_data,
    output logic              busy,
    output logic              done,
    output logic              run_div,
    output logic              sck_lvl,
    output logic              out_bit,
    output logic [DATA_W-1:0] shreg
);

    localparam int unsigned EDGES = 2 * DATA_W;
    localparam int unsigned EW    = $clog2(EDGES);

    xfer_state_t st_q, st_n;
    logic [EW-1:0] ecnt;
    logic          sck_prev;
    logic          edge_ev;
    logic          sample;
    logic          last;

    assign edge_ev = master ? tick : (sck_s != sck_prev);
    assign sample  = (ecnt[0] == cpha);
    assign last    = edge_ev && (ecnt == EW'(EDGES-1));

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (!abort && active) begin
                    if (master) begin
                        if (load) st_n = ST_RUN;
                    end else if (ss_lo) begin
                        st_n = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (abort || !active || (!master && !ss_lo)) st_n = ST_IDLE;
                else if (last)                              st_n = ST_DONE;
            end
            ST_DONE: st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ecnt     <= '0;
            sck_lvl  <= 1'b0;
            out_bit  <= 1'b0;
            shreg    <= '0;
            sck_prev <= 1'b0;
        end else begin
            sck_prev <= sck_s;
            if (st_q != ST_RUN) begin
                ecnt    <= '0;
                sck_lvl <= cpol;
                if (load) begin
                    shreg   <= load_data;
                    out_bit <= load_data[DATA_W-1];
                end
            end else if (edge_ev) begin
                ecnt    <= ecnt + 1'b1;
                sck_lvl <= ~sck_lvl;
                if (sample) shreg   <= {shreg[DATA_W-2:0], master ? din_m : din_s};
                else        out_bit <= shreg[DATA_W-1];
            end
        end
    end

    assign busy    = (st_q != ST_IDLE);
    assign done    = (st_q == ST_DONE);
    assign run_div = (st_q == ST_RUN) && master;

    // R4
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && $past(st_q == ST_IDLE) && $stable(cpol)) |-> (sck_lvl == cpol));

    // R6
    done_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE) |-> ($past(st_q) == ST_RUN));

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             irq,
    input  logic             sck_i,
    output logic             sck_o,
    output logic             sck_oe,
    input  logic             mosi_i,
    output logic             mosi_o,
    output logic             mosi_oe,
    input  logic             miso_i,
    output logic             miso_o,
    output logic             miso_oe,
    input  logic             ss_n,
    output logic             gpio_sel
);

    localparam int unsigned DATA_W = REG_W;

    logic [REG_W-1:0]  ctl_q, ctl_n;
    logic [DATA_W-1:0] rx_q, shreg;
    logic spif_q, wcol_q, ovr_q, modf_q, armed_q;
    logic sck_s, ss_s, mosi_s, ss_lo;
    logic busy, done, run_div, sck_lvl, out_bit, tick;
    logic ctl_wr, data_wr, data_acc, stat_rd, clr, fault, load, collide, keep_old;
    logic pe, ms;

    spi_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b010)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .d({sck_i, ss_n, mosi_i}),
        .q({sck_s, ss_s, mosi_s})
    );

    assign pe       = ctl_q[C_PE];
    assign ms       = ctl_q[C_MS];
    assign ss_lo    = ~ss_s;
    assign ctl_wr   = wr_en && (addr == A_CTL);
    assign data_wr  = wr_en && (addr == A_DATA);
    assign data_acc = (wr_en || rd_en) && (addr == A_DATA);
    assign stat_rd  = rd_en && (addr == A_STAT);
    assign clr      = armed_q && data_acc;
    assign fault    = pe && ms && ss_lo;
    assign load     = data_wr && !busy;
    assign collide  = data_wr && busy;
    assign keep_old = spif_q && !clr;

    spi_rate_div i_div (
        .clk(clk), .rst_n(rst_n), .run(run_div),
        .code({ctl_q[C_R2], ctl_q[1:0]}), .tick(tick)
    );

    spi_engine #(.DATA_W(DATA_W)) i_eng (
        .clk(clk), .rst_n(rst_n),
        .master(ms), .active(pe),
        .cpol(ctl_q[C_CPOL]), .cpha(ctl_q[C_CPHA]),
        .tick(tick), .sck_s(sck_s), .ss_lo(ss_lo),
        .load(load), .abort(fault),
        .din_m(miso_i), .din_s(mosi_s), .load_data(wdata),
        .busy(busy), .done(done), .run_div(run_div),
        .sck_lvl(sck_lvl), .out_bit(out_bit), .shreg(shreg)
    );

    always_comb begin
        ctl_n = ctl_wr ? wdata : ctl_q;
        if (fault) begin
            ctl_n[C_PE] = 1'b0;
            ctl_n[C_MS] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            rx_q    <= '0;
            spif_q  <= 1'b0;
            wcol_q  <= 1'b0;
            ovr_q   <= 1'b0;
            modf_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            ctl_q   <= ctl_n;
            spif_q  <= (spif_q && !clr) || done;
            wcol_q  <= (wcol_q && !clr) || collide;
            ovr_q   <= (ovr_q  && !clr) || (done && keep_old);
            modf_q  <= (modf_q && !clr) || fault;
            if (done && !keep_old) rx_q <= shreg;
            if (data_acc)     armed_q <= 1'b0;
            else if (stat_rd) armed_q <= 1'b1;
        end
    end

    always_comb begin
        case (addr)
            A_CTL:   rdata = ctl_q;
            A_STAT:  rdata = {spif_q, wcol_q, ovr_q, modf_q, 4'b0000};
            A_DATA:  rdata = rx_q;
            default: rdata = '0;
        endcase
    end

    assign irq      = ctl_q[C_IE] && (spif_q || modf_q);
    assign sck_o    = ms ? sck_lvl : ctl_q[C_CPOL];
    assign sck_oe   = pe && ms;
    assign mosi_o   = out_bit;
    assign mosi_oe  = pe && ms;
    assign miso_o   = out_bit;
    assign miso_oe  = pe && !ms && ss_lo;
    assign gpio_sel = !pe;

    // R11
    fault_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!ctl_q[C_MS] && !ctl_q[C_PE] && modf_q));

    // R8
    collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> (wcol_q && busy));

    // R9
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && keep_old) |=> (ovr_q && $stable(rx_q)));

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !done && !fault && !collide) |=> (!spif_q && !wcol_q && !ovr_q && !modf_q));

endmodule

// File: tb/test_spi_port.sv
module test_spi_port;
    import spi_pkg::*;

    localparam time CLK_P = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, gpio_sel;
    logic sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n = 1'b1;

    int nchk = 0;
    int nerr = 0;
    logic [7:0] sb_q[$];
    string      sb_tag[$];

    // bench slave model state
    logic       s_cpol = 1'b0, s_cpha = 1'b0, slv_on = 1'b0;
    logic [7:0] s_txv = '0, s_tx = '0, s_rx = '0;
    int         s_cnt = 0, s_arm = 0, s_arm_seen = 0;

    always #(CLK_P/2) clk = ~clk;

    spi_port i_spi_port (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_n(ss_n), .gpio_sel(gpio_sel)
    );

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic sb_cmp(input logic [7:0] got);
        if (sb_q.size() == 0) begin
            check("R6 scoreboard underflow", 1, 0);
        end else begin
            check(sb_tag.pop_front(), got, sb_q.pop_front());
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic slv_arm(input logic cp, input logic ph, input logic [7:0] tx);
        s_cpol = cp; s_cpha = ph; s_txv = tx;
        s_arm++;
    endtask

    // Monitor: behavioural slave on the master's SCK, pops expected MOSI bytes.
    always @(sck_o or s_arm) begin
        if (s_arm != s_arm_seen) begin
            s_arm_seen = s_arm;
            s_tx = s_txv; s_cnt = 0; slv_on = 1'b1;
            if (!s_cpha) begin miso_i = s_tx[7]; s_tx = s_tx << 1; end
        end else if (slv_on && sck_oe) begin
            if ((sck_o != s_cpol) ^ s_cpha) begin
                s_rx = {s_rx[6:0], mosi_o};
                s_cnt++;
                if (s_cnt == 8) begin
                    slv_on = 1'b0;
                    sb_cmp(s_rx);
                end
            end else begin
                miso_i = s_tx[7]; s_tx = s_tx << 1;
            end
        end
    end

    task automatic measure(input int exp, input string req);
        realtime t0, t1;
        @(posedge sck_o); t0 = $realtime;
        @(posedge sck_o); t1 = $realtime;
        check(req, int'((t1 - t0) / CLK_P), exp);
    endtask

    // Driver: master transfer, expected MOSI byte goes to the scoreboard.
    task automatic mxfer(input logic [7:0] ctl, input logic [7:0] tx,
                         input logic [7:0] stx, input int period);
        wr(A_CTL, ctl);
        idle(2);
        slv_arm(ctl[C_CPOL], ctl[C_CPHA], stx);
        sb_q.push_back(tx); sb_tag.push_back("R5 MOSI byte MSB first");
        fork
            wr(A_DATA, tx);
            measure(period, "R3 SCK period");
        join
    endtask

    task automatic wait_done(output logic [7:0] v);
        v = '0;
        for (int i = 0; i < 4000; i++) begin
            rd(A_STAT, v);
            if (v[7]) break;
        end
    endtask

    // Driver and monitor for slave transfers: bench acts as master.
    task automatic sxfer(input logic [7:0] tx, input logic [7:0] exp,
                         input logic cp, input logic ph);
        logic [7:0] b, got;
        got = '0;
        sb_q.push_back(exp); sb_tag.push_back("R7 MISO byte");
        @(negedge clk);
        sck_i = cp; b = tx;
        if (!ph) begin mosi_i = b[7]; b = b << 1; end
        idle(8);
        ss_n = 1'b0;
        idle(8);
        check("R13 miso_oe in frame", miso_oe, 1);
        for (int e = 0; e < 16; e++) begin
            sck_i = ~sck_i;
            if ((e[0] == 1'b0) ^ ph) got = {got[6:0], miso_o};
            else begin mosi_i = b[7]; b = b << 1; end
            idle(8);
        end
        ss_n = 1'b1;
        sb_cmp(got);
        idle(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(A_CTL, v);  check("R1 ctl reset", v, 8'h00);
        rd(A_STAT, v); check("R1 status reset", v, 8'h00);
        check("R1 irq", irq, 0);
        check("R1 gpio_sel", gpio_sel, 1);
        check("R1 sck_o", sck_o, 0);
        check("R1 oe", {sck_oe, mosi_oe, miso_oe}, 0);
        rd(A_DATA, v);

        // R2 readback, R13 ownership, R3 /2, CPOL0 CPHA0
        wr(A_CTL, 8'h70);
        rd(A_CTL, v); check("R2 ctl readback", v, 8'h70);
        check("R13 gpio_sel enabled", gpio_sel, 0);
        check("R13 master oe", {sck_oe, mosi_oe, miso_oe}, 3'b110);
        mxfer(8'h70, 8'hA5, 8'h3C, 2);
        wait_done(v); check("R6 done flag", v, 8'h80);
        check("R12 irq masked", irq, 0);
        rd(A_DATA, v); check("R6 rx byte", v, 8'h3C);
        rd(A_STAT, v); check("R10 flags cleared", v, 8'h00);

        // R4 idle high, CPOL1 CPHA1 /4
        wr(A_CTL, 8'h5C); idle(3);
        check("R4 idle level high", sck_o, 1);
        mxfer(8'h5C, 8'h96, 8'h5A, 4);
        wait_done(v);
        rd(A_DATA, v); check("R5 rx CPOL1 CPHA1", v, 8'h5A);

        // CPOL0 CPHA1 /16
        mxfer(8'h76, 8'h01, 8'h80, 16);
        wait_done(v);
        rd(A_DATA, v); check("R5 rx CPOL0 CPHA1", v, 8'h80);

        // R3 unused code 111 -> /64, R8 collision
        mxfer(8'h7B, 8'hF0, 8'h0F, 64);
        wr(A_DATA, 8'h55);
        wait_done(v); check("R8 collision flag", v, 8'hC0);
        rd(A_DATA, v); check("R8 byte in flight kept", v, 8'h0F);
        rd(A_STAT, v); check("R10 flags cleared", v, 8'h00);

        // R9 overrun, R12 interrupt
        wr(A_CTL, 8'hF0); idle(2);
        slv_arm(1'b0, 1'b0, 8'h22);
        sb_q.push_back(8'h11); sb_tag.push_back("R9 first byte");
        wr(A_DATA, 8'h11); idle(40);
        check("R12 irq on done", irq, 1);
        slv_arm(1'b0, 1'b0, 8'h44);
        sb_q.push_back(8'h33); sb_tag.push_back("R9 second byte");
        wr(A_DATA, 8'h33); idle(40);
        rd(A_STAT, v); check("R9 overrun flag", v, 8'hA0);
        rd(A_DATA, v); check("R9 earlier byte kept", v, 8'h22);
        rd(A_STAT, v); check("R10 flags cleared", v, 8'h00);
        check("R12 irq cleared", irq, 0);

        // R7 slave, rate bits set but ignored
        wr(A_CTL, 8'h43);
        wr(A_DATA, 8'hC3);
        idle(2);
        check("R13 slave oe outside frame", {sck_oe, mosi_oe, miso_oe}, 3'b000);
        sxfer(8'h69, 8'hC3, 1'b0, 1'b0);
        rd(A_STAT, v); check("R7 slave done", v, 8'h80);
        rd(A_DATA, v); check("R7 slave rx", v, 8'h69);

        wr(A_CTL, 8'h4C);
        wr(A_DATA, 8'h5E);
        sxfer(8'hB2, 8'h5E, 1'b1, 1'b1);
        rd(A_STAT, v); check("R7 slave done CPHA1", v, 8'h80);
        rd(A_DATA, v); check("R7 slave rx CPHA1", v, 8'hB2);

        // R11 mode fault
        wr(A_CTL, 8'hD0); idle(2);
        check("R13 master owns pins", gpio_sel, 0);
        ss_n = 1'b0; idle(6);
        rd(A_CTL, v);  check("R11 ctl bits dropped", v, 8'h80);
        rd(A_STAT, v); check("R11 fault flag", v, 8'h10);
        check("R12 irq on fault", irq, 1);
        check("R13 pins released", gpio_sel, 1);
        ss_n = 1'b1;
        rd(A_DATA, v);
        rd(A_STAT, v); check("R10 fault cleared", v, 8'h00);
        check("R12 irq after clear", irq, 0);

        check("R6 scoreboard drained", sb_q.size(), 0);
        finish_run();
    end

endmodule